// File: doc/BRIEF.md
# Capacitive Wake-Up Event Detector

This block sits behind a two-channel capacitance-to-digital converter. For each channel it takes 12-bit results, stores the latest one with its overrange flag, and decides whether the sample is a wake-up event. Two tests feed the decision. The level test compares the upper byte of the sample against a level threshold. The slope test compares the absolute difference between the upper bytes of the current and previous samples against a slope threshold. A per-channel select merges the two tests with AND or OR, and each test has its own enable.

A wake-up event clears a shared standby flag and sets that channel's sticky wake status bit. Every accepted sample sets that channel's ready status bit. A host reaches the configuration, status, mask and results through a byte-wide register port. A masked OR of the status bits drives the interrupt output. Each channel can be powered down separately. When both channels are down, the shared excitation enable turns off and all sample and status state is cleared, while the configuration is kept.

Top module: `capwake_detect`

## Requirements
- R1: An accepted sample on channel c is stored and can be read back at address 8+8c+3 (result bits 7:0) and 8+8c+4 (bits 3:0 = result bits 11:8, bit 7 = overrange flag of that sample). A newer sample overwrites an unread one.
- R2: An accepted sample on channel c sets bit c of STAT (address 1) at the clock edge that takes it.
- R3: The level test is hit when result bits 11:4 are strictly greater than the level threshold at address 8+8c+1.
- R4: The slope test is hit when the absolute difference between bits 11:4 of the current and the stored sample is strictly greater than the slope threshold at address 8+8c+2. It is never hit before the channel holds a sample taken since reset or since its last power-down.
- R5: Channel config at address 8+8c+0 has bit 0 = level enable, bit 1 = slope enable, bit 2 = combine select (1 = AND, 0 = OR). A disabled test counts as 0 under OR and as 1 under AND. With both tests disabled, no wake-up is produced.
- R6: A wake-up on channel c sets STAT bit 2+c and clears the standby flag (CTRL bit 4, also the standby output). A host write to CTRL loads bit 4, and a wake-up in the same cycle takes priority.
- R7: STAT bits are sticky and clear when written with 1. A set and a clear of the same bit in the same cycle leave it set.
- R8: irq is high exactly when some STAT bit is set and the bit at the same position of MASK (address 2) is 1.
- R9: CTRL bit c = 1 powers down channel c. A powered-down channel ignores samples, so its STAT bits and result do not change, and it forgets its previous sample for the slope test.
- R10: With both CTRL power-down bits set, excite_en is low and, from the next edge, all results, overrange flags and STAT are zero. CTRL, MASK, configuration and thresholds are kept.
- R11: After reset CTRL reads 0x10 (both channels up, standby set), and STAT, MASK, configuration, thresholds and results read 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 2 | Per-channel sample strobe, one cycle |
| conv_data | input | 24 | Samples, channel c in bits 12c+11:12c |
| conv_ovr | input | 2 | Per-channel overrange flag of the sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Masked interrupt request |
| excite_en | output | 1 | Shared excitation enable, low when both channels are down |
| standby | output | 1 | Standby flag, cleared by a wake-up |

## Verification
The bench goes after the threshold edges. A sample whose upper byte equals the level threshold, or whose slope equals the slope threshold, must not wake, so a design that used greater-or-equal would set a wake bit early. It checks the first sample after reset or power-up, where a design that kept a stale previous value would produce a false slope wake. It also checks the neutral value of a disabled test under AND and under OR. The same-cycle collisions are covered: a clear racing a set, and a standby write racing a wake-up. So are single and dual power-down, where a design that leaked strobes would change the status, or one that did not flush would keep stale results.

// File: rtl/capwake_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register addresses and the per-channel
// configuration record of the capacitive wake-up detector.
package capwake_pkg;
    localparam int RES_W     = 12;          // converter result width
    localparam int CMP_W     = 8;           // upper bits used in the tests
    localparam int REG_W     = 8;           // host register width
    localparam int ADDR_CTRL = 0;           // power-down bits and standby
    localparam int ADDR_STAT = 1;           // sticky status, write 1 to clear
    localparam int ADDR_MASK = 2;           // interrupt mask
    localparam int CH_BASE   = 8;           // first channel block
    localparam int CH_STRIDE = 8;           // spacing of channel blocks
    localparam int OFS_CFG   = 0;
    localparam int OFS_LVL   = 1;
    localparam int OFS_SLP   = 2;
    localparam int OFS_RLO   = 3;
    localparam int OFS_RHI   = 4;
    localparam int STBY_BIT  = 4;           // standby position in CTRL
    localparam int OVR_BIT   = REG_W - 1;   // overrange position in result high byte

    typedef struct packed {
        logic             and_sel;   // 1: AND the tests, 0: OR
        logic             slope_en;
        logic             level_en;
        logic [CMP_W-1:0] level_th;
        logic [CMP_W-1:0] slope_th;
    } chan_cfg_t;
endpackage

// File: rtl/capwake_chan.sv
`timescale 1ns/1ps
// Module: capwake_chan
// One detector channel. It holds the latest sample and its overrange flag,
// and it evaluates the level and slope tests on an incoming strobe
// against the configured thresholds.
// Assumes: cfg is stable registered state; flush has priority over all.
module capwake_chan
    import capwake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,        // this channel powered down
    input  logic             flush,     // both channels down: clear state
    input  logic             strobe,
    input  logic [RES_W-1:0] data,
    input  logic             ovr_in,
    input  chan_cfg_t        cfg,
    output logic [RES_W-1:0] res,
    output logic             res_ovr,
    output logic             accept,
    output logic             wake
);
    logic             have_prev;
    logic [CMP_W-1:0] cur_hi, prev_hi, delta;
    logic             level_hit, slope_hit, level_term, slope_term;

    // Evaluate both tests and merge them with the selected operator.
    always_comb begin
        cur_hi     = data[RES_W-1 -: CMP_W];
        prev_hi    = res[RES_W-1 -: CMP_W];
        delta      = (cur_hi >= prev_hi) ? (cur_hi - prev_hi) : (prev_hi - cur_hi);
        level_hit  = cur_hi > cfg.level_th;
        slope_hit  = have_prev && (delta > cfg.slope_th);
        level_term = cfg.level_en ? level_hit : cfg.and_sel;
        slope_term = cfg.slope_en ? slope_hit : cfg.and_sel;
        accept     = strobe && !pd;
        wake       = accept && (cfg.level_en || cfg.slope_en) &&
                     (cfg.and_sel ? (level_term && slope_term)
                                  : (level_term || slope_term));
    end

    // Sample storage: cleared on flush, previous sample dropped while down.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            res       <= '0;
            res_ovr   <= 1'b0;
            have_prev <= 1'b0;
        end else if (pd) begin
            have_prev <= 1'b0;
        end else if (strobe) begin
            res       <= data;
            res_ovr   <= ovr_in;
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/capwake_regs.sv
`timescale 1ns/1ps
// Module: capwake_regs
// Host register file: control, sticky status, mask and per-channel
// configuration, plus the combinational read mux over all of it.
// Assumes: at most four channels, so the status fits in one byte.
module capwake_regs
    import capwake_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    input  logic [NCH-1:0]            accept,
    input  logic [NCH-1:0]            wake,
    input  logic [NCH-1:0][RES_W-1:0] res,
    input  logic [NCH-1:0]            res_ovr,
    output logic [REG_W-1:0]          rdata,
    output chan_cfg_t [NCH-1:0]       cfg,
    output logic [NCH-1:0]            pd,
    output logic [2*NCH-1:0]          stat,
    output logic [2*NCH-1:0]          mask,
    output logic                      standby
);
    localparam int STAT_W = 2 * NCH;

    function automatic logic [ADDR_W-1:0] ch_addr(input int c, input int ofs);
        return ADDR_W'(CH_BASE + c * CH_STRIDE + ofs);
    endfunction

    logic              wr_stat;
    logic [STAT_W-1:0] clr_bits, set_bits;

    // Decode the clear and set vectors applied to the sticky status.
    always_comb begin
        wr_stat  = wr && (addr == ADDR_W'(ADDR_STAT));
        clr_bits = wr_stat ? wdata[STAT_W-1:0] : '0;
        set_bits = {wake, accept};
    end

    // Control, mask, configuration and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd      <= '0;
            standby <= 1'b1;
            mask    <= '0;
            stat    <= '0;
            cfg     <= '0;
        end else begin
            if (wr && addr == ADDR_W'(ADDR_CTRL)) begin
                pd      <= wdata[NCH-1:0];
                standby <= wdata[STBY_BIT];
            end
            if (|wake) standby <= 1'b0;
            if (wr && addr == ADDR_W'(ADDR_MASK)) mask <= wdata[STAT_W-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (wr && addr == ch_addr(c, OFS_CFG)) begin
                    cfg[c].level_en <= wdata[0];
                    cfg[c].slope_en <= wdata[1];
                    cfg[c].and_sel  <= wdata[2];
                end
                if (wr && addr == ch_addr(c, OFS_LVL)) cfg[c].level_th <= wdata;
                if (wr && addr == ch_addr(c, OFS_SLP)) cfg[c].slope_th <= wdata;
            end
            if (&pd) stat <= '0;
            else     stat <= (stat & ~clr_bits) | set_bits;
        end
    end

    // Read mux: fixed registers first, then each channel block.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[NCH-1:0]  = pd;
            rdata[STBY_BIT] = standby;
        end
        if (addr == ADDR_W'(ADDR_STAT)) rdata[STAT_W-1:0] = stat;
        if (addr == ADDR_W'(ADDR_MASK)) rdata[STAT_W-1:0] = mask;
        for (int c = 0; c < NCH; c++) begin
            if (addr == ch_addr(c, OFS_CFG))
                rdata[2:0] = {cfg[c].and_sel, cfg[c].slope_en, cfg[c].level_en};
            if (addr == ch_addr(c, OFS_LVL)) rdata = cfg[c].level_th;
            if (addr == ch_addr(c, OFS_SLP)) rdata = cfg[c].slope_th;
            if (addr == ch_addr(c, OFS_RLO)) rdata = res[c][REG_W-1:0];
            if (addr == ch_addr(c, OFS_RHI)) begin
                rdata[RES_W-REG_W-1:0] = res[c][RES_W-1:REG_W];
                rdata[OVR_BIT]         = res_ovr[c];
            end
        end
    end
endmodule

// File: rtl/capwake_detect.sv
`timescale 1ns/1ps
// Module: capwake_detect (top)
// Two-channel capacitive wake-up detector: per-channel sample storage and
// wake decision, host register file, masked interrupt and the shared
// excitation enable.
// Assumes: conv_valid is a single-cycle strobe per sample.
module capwake_detect
    import capwake_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       conv_valid,
    input  logic [NCH*RES_W-1:0] conv_data,
    input  logic [NCH-1:0]       conv_ovr,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq,
    output logic                 excite_en,
    output logic                 standby
);
    chan_cfg_t [NCH-1:0]       cfg;
    logic [NCH-1:0]            pd_q, accept, wake, res_ovr;
    logic [NCH-1:0][RES_W-1:0] res;
    logic [2*NCH-1:0]          stat_q, mask_q;
    logic                      flush;

    // Shared outputs derived from the register state.
    always_comb begin
        flush     = &pd_q;
        excite_en = !flush;
        irq       = |(stat_q & mask_q);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        capwake_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pd     (pd_q[c]),
            .flush  (flush),
            .strobe (conv_valid[c]),
            .data   (conv_data[c*RES_W +: RES_W]),
            .ovr_in (conv_ovr[c]),
            .cfg    (cfg[c]),
            .res    (res[c]),
            .res_ovr(res_ovr[c]),
            .accept (accept[c]),
            .wake   (wake[c])
        );
    end

    capwake_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .accept (accept),
        .wake   (wake),
        .res    (res),
        .res_ovr(res_ovr),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .pd     (pd_q),
        .stat   (stat_q),
        .mask   (mask_q),
        .standby(standby)
    );
endmodule

// File: rtl/capwake_chk.sv
`timescale 1ns/1ps
// Module: capwake_chk
// Property checker bound into capwake_detect. It watches strobes,
// power-down state, sticky status, standby and irq.
module capwake_chk
    import capwake_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    conv_valid,
    input logic [NCH-1:0]    pd,
    input logic [2*NCH-1:0]  stat,
    input logic              standby,
    input logic              irq,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr
);
    logic stat_wr;
    assign stat_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));

    for (genvar c = 0; c < NCH; c++) begin : g_prop
        // R2 and R7: an accepted strobe leaves the ready bit set, even against a clear
        assert_rdy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_valid[c] && !pd[c]) |=> stat[c])
            else $error("ready bit not set after accepted sample");
        // R6: a wake bit only rises together with standby going low
        assert_wake_stby_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[NCH+c]) |-> !standby)
            else $error("wake status rose with standby still set");
        // R9: a powered-down channel keeps its status unless the host clears it
        assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pd[c] && !(&pd) && !stat_wr) |=> ($stable(stat[c]) && $stable(stat[NCH+c])))
            else $error("status of powered-down channel changed");
    end

    // R10: both channels down flushes status and silences irq
    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&pd) |=> (stat == '0 && !irq))
        else $error("status not flushed with both channels down");
endmodule

bind capwake_detect capwake_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_valid(conv_valid),
    .pd        (pd_q),
    .stat      (stat_q),
    .standby   (standby),
    .irq       (irq),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr)
);

// File: tb/sim_capwake_detect.sv
`timescale 1ns/1ps
// Bench for capwake_detect: directed corner cases followed by seeded
// random traffic, all compared against a bench-side behavioural model.
module sim_capwake_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  conv_valid = '0;
    logic [23:0] conv_data = '0;
    logic [1:0]  conv_ovr = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq, excite_en, standby;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    capwake_detect u0 (.*);

    // Behavioural model state
    logic [1:0]  m_pd;
    logic        m_stby;
    logic [3:0]  m_mask, m_stat;
    logic [2:0]  m_cfg[2];
    logic [7:0]  m_lvl[2], m_slp[2];
    logic [11:0] m_res[2];
    logic        m_ovr[2], m_val[2];

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic model_wake(input int c, input logic [11:0] d);
        logic [7:0] hi, ph, dl;
        logic lv, sl, lt, st;
        hi = d[11:4];
        ph = m_res[c][11:4];
        dl = (hi >= ph) ? hi - ph : ph - hi;
        lv = hi > m_lvl[c];
        sl = m_val[c] && (dl > m_slp[c]);
        lt = m_cfg[c][0] ? lv : m_cfg[c][2];
        st = m_cfg[c][1] ? sl : m_cfg[c][2];
        if (!(m_cfg[c][0] || m_cfg[c][1])) return 1'b0;
        return m_cfg[c][2] ? (lt && st) : (lt || st);
    endfunction

    function automatic logic [7:0] model_read(input logic [4:0] a);
        logic [7:0] r;
        r = '0;
        case (a)
            5'd0: r = {3'b0, m_stby, 2'b0, m_pd};
            5'd1: r = {4'b0, m_stat};
            5'd2: r = {4'b0, m_mask};
            default: ;
        endcase
        for (int c = 0; c < 2; c++) begin
            if (a == 5'(8 + 8*c))     r = {5'b0, m_cfg[c]};
            if (a == 5'(8 + 8*c + 1)) r = m_lvl[c];
            if (a == 5'(8 + 8*c + 2)) r = m_slp[c];
            if (a == 5'(8 + 8*c + 3)) r = m_res[c][7:0];
            if (a == 5'(8 + 8*c + 4)) r = {m_ovr[c], 3'b0, m_res[c][11:8]};
        end
        return r;
    endfunction

    task automatic model_reset();
        m_pd = '0; m_stby = 1'b1; m_mask = '0; m_stat = '0;
        for (int c = 0; c < 2; c++) begin
            m_cfg[c] = '0; m_lvl[c] = '0; m_slp[c] = '0;
            m_res[c] = '0; m_ovr[c] = 1'b0; m_val[c] = 1'b0;
        end
    endtask

    // One clock: drive inputs, update the model, wait for the edge.
    task automatic do_cycle(input logic [1:0] v, input logic [11:0] d0, input logic [11:0] d1,
                            input logic [1:0] o, input logic w, input logic [4:0] a, input logic [7:0] wd);
        logic [3:0] setb;
        logic [11:0] dd[2];
        logic wk;
        dd[0] = d0; dd[1] = d1;
        setb = '0; wk = 1'b0;
        conv_valid = v; conv_data = {d1, d0}; conv_ovr = o;
        reg_wr = w; reg_addr = a; reg_wdata = wd;
        if (&m_pd) begin
            m_stat = '0;
            for (int c = 0; c < 2; c++) begin m_res[c] = '0; m_ovr[c] = 1'b0; m_val[c] = 1'b0; end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (m_pd[c]) m_val[c] = 1'b0;
                else if (v[c]) begin
                    setb[c] = 1'b1;
                    if (model_wake(c, dd[c])) begin setb[2+c] = 1'b1; wk = 1'b1; end
                    m_res[c] = dd[c]; m_ovr[c] = o[c]; m_val[c] = 1'b1;
                end
            end
        end
        if (w) begin
            if (a == 5'd0) begin m_pd = wd[1:0]; m_stby = wd[4]; end
            if (a == 5'd1 && !(&m_pd)) m_stat = m_stat & ~wd[3:0];
            if (a == 5'd2) m_mask = wd[3:0];
            for (int c = 0; c < 2; c++) begin
                if (a == 5'(8 + 8*c))     m_cfg[c] = wd[2:0];
                if (a == 5'(8 + 8*c + 1)) m_lvl[c] = wd;
                if (a == 5'(8 + 8*c + 2)) m_slp[c] = wd;
            end
        end
        m_stat = m_stat | setb;
        if (wk) m_stby = 1'b0;
        @(posedge clk);
        #1;
        conv_valid = '0; reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        do_cycle(2'b00, 12'h0, 12'h0, 2'b00, 1'b1, a, d);
    endtask

    task automatic conv(input logic [1:0] v, input logic [11:0] d0, input logic [11:0] d1, input logic [1:0] o);
        do_cycle(v, d0, d1, o, 1'b0, 5'd0, 8'h0);
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, $sformatf("reg %0d", a), v, exp);
    endtask

    // Full comparison of outputs and every mapped register against the model.
    task automatic check_all(input string tag);
        logic [4:0] alist[13] = '{5'd0, 5'd1, 5'd2, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12,
                                  5'd16, 5'd17, 5'd18, 5'd19, 5'd20};
        logic [7:0] v;
        chk("R8", {tag, " irq"}, irq, |(m_stat & m_mask));
        chk("R10", {tag, " excite_en"}, excite_en, !(&m_pd));
        chk("R6", {tag, " standby"}, standby, m_stby);
        for (int i = 0; i < 13; i++) begin
            rd(alist[i], v);
            chk("R1/R2", $sformatf("%s reg %0d", tag, alist[i]), v, model_read(alist[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4177));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: reset values
        expect_reg("R11", 5'd0, 8'h10);
        expect_reg("R11", 5'd1, 8'h00);
        expect_reg("R11", 5'd11, 8'h00);
        expect_reg("R11", 5'd7, 8'h00);
        chk("R11", "irq", irq, 1'b0);
        check_all("R11 reset");

        // R3: level test, equal is not a crossing
        wr(5'd8, 8'h01); wr(5'd9, 8'h80);
        conv(2'b01, 12'h800, 12'h0, 2'b00);
        expect_reg("R3", 5'd1, 8'h01);
        expect_reg("R6", 5'd0, 8'h10);
        conv(2'b01, 12'h81F, 12'h0, 2'b01);
        expect_reg("R3", 5'd1, 8'h05);
        expect_reg("R6", 5'd0, 8'h00);
        expect_reg("R1", 5'd11, 8'h1F);
        expect_reg("R1", 5'd12, 8'h88);
        // R7: clear racing a set leaves the bit set
        do_cycle(2'b01, 12'h100, 12'h0, 2'b00, 1'b1, 5'd1, 8'h01);
        expect_reg("R7", 5'd1, 8'h05);
        expect_reg("R1", 5'd12, 8'h01);
        wr(5'd1, 8'h05);
        expect_reg("R7", 5'd1, 8'h00);

        // R4: slope test on channel 1, threshold 5
        wr(5'd16, 8'h02); wr(5'd18, 8'h05);
        conv(2'b10, 12'h0, 12'h100, 2'b00);
        expect_reg("R4", 5'd1, 8'h02);
        conv(2'b10, 12'h0, 12'h160, 2'b00);
        expect_reg("R4", 5'd1, 8'h0A);
        wr(5'd1, 8'h0F);
        conv(2'b10, 12'h0, 12'h100, 2'b00);
        expect_reg("R4", 5'd1, 8'h0A);
        wr(5'd1, 8'h0F);
        conv(2'b10, 12'h0, 12'h150, 2'b00);
        expect_reg("R4", 5'd1, 8'h02);
        wr(5'd1, 8'h0F);

        // R5: disabled tests and AND/OR combine
        wr(5'd16, 8'h00); wr(5'd17, 8'h00);
        conv(2'b10, 12'h0, 12'hFFF, 2'b00);
        expect_reg("R5", 5'd1, 8'h02);
        wr(5'd1, 8'h0F);
        wr(5'd16, 8'h07); wr(5'd17, 8'h80);
        conv(2'b10, 12'h0, 12'hF00, 2'b00);
        expect_reg("R5", 5'd1, 8'h0A);
        wr(5'd1, 8'h0F);
        conv(2'b10, 12'h0, 12'hF10, 2'b00);
        expect_reg("R5", 5'd1, 8'h02);
        wr(5'd1, 8'h0F);
        wr(5'd16, 8'h05);
        conv(2'b10, 12'h0, 12'hF10, 2'b00);
        expect_reg("R5", 5'd1, 8'h0A);
        wr(5'd1, 8'h0F);
        wr(5'd16, 8'h03);
        conv(2'b10, 12'h0, 12'h100, 2'b00);
        expect_reg("R5", 5'd1, 8'h0A);
        wr(5'd1, 8'h0F);

        // R6: wake wins over a same-cycle standby write
        do_cycle(2'b10, 12'h0, 12'hF00, 2'b00, 1'b1, 5'd0, 8'h10);
        chk("R6", "standby after race", standby, 1'b0);
        wr(5'd1, 8'h0F);

        // R8: mask gating
        conv(2'b01, 12'h010, 12'h0, 2'b00);
        chk("R8", "irq masked", irq, 1'b0);
        wr(5'd2, 8'h01);
        chk("R8", "irq unmasked", irq, 1'b1);
        wr(5'd2, 8'h02);
        chk("R8", "irq other bit", irq, 1'b0);
        wr(5'd1, 8'h0F);

        // R9: single power-down ignores samples and forgets the previous one
        wr(5'd0, 8'h01);
        conv(2'b01, 12'hABC, 12'h0, 2'b01);
        expect_reg("R9", 5'd1, 8'h00);
        expect_reg("R9", 5'd11, 8'h10);
        chk("R9", "excite one down", excite_en, 1'b1);
        wr(5'd0, 8'h00);
        wr(5'd8, 8'h02); wr(5'd10, 8'h00);
        conv(2'b01, 12'hFFF, 12'h0, 2'b00);
        expect_reg("R9", 5'd1, 8'h01);
        wr(5'd1, 8'h0F);

        // R10: both down flushes state, keeps configuration
        conv(2'b11, 12'h321, 12'h654, 2'b11);
        wr(5'd0, 8'h03);
        chk("R10", "excite both down", excite_en, 1'b0);
        conv(2'b11, 12'h777, 12'h777, 2'b00);
        expect_reg("R10", 5'd1, 8'h00);
        expect_reg("R10", 5'd19, 8'h00);
        expect_reg("R10", 5'd12, 8'h00);
        expect_reg("R10", 5'd9, 8'h80);
        expect_reg("R10", 5'd16, 8'h03);
        wr(5'd0, 8'h00);
        check_all("R10 after");

        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [1:0] v2;
            logic       w;
            logic [4:0] a;
            logic [7:0] wd;
            int         sel;
            v2 = 2'($urandom);
            w  = ($urandom % 3) == 0;
            sel = $urandom % 8;
            wd = 8'($urandom);
            case (sel)
                0: a = 5'd0;
                1, 2: a = 5'd1;
                3: a = 5'd2;
                default: a = 5'(8 + 8*($urandom % 2) + ($urandom % 3));
            endcase
            if (a == 5'd0 && ($urandom % 4) != 0) wd[1:0] = 2'b00;
            do_cycle(v2, 12'($urandom), 12'($urandom), 2'($urandom), w, a, wd);
            check_all($sformatf("R1 R2 R3 R4 R5 R7 R9 random %0d", i));
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule